// File: doc/BRIEF.md
# Dual-Clock FIFO with Flush from Either Side

This block is a first-in first-out buffer whose writer and reader run on unrelated clocks. Each side sees its own view of the fill level as a 4-bit quantized status code and as one threshold bit. The producer gets an almost-full bit. The consumer gets an almost-empty bit. Read and write positions cross between the domains as Gray-coded counters through two-stage synchronizers.

Either side can discard the whole contents with a one-cycle flush request on its own clock. The requesting side clears its own position at once and raises its `*_flushing` output. While that output is high, its status outputs are not valid, and it refuses its own data requests. The request goes to the other domain as a level toggle. The other domain clears its position and toggles an acknowledge back. When the acknowledge arrives, the requester drops `*_flushing`, and its flags then show the buffer empty. Data written before the flush can never be read after it. The completion delay depends on the phase of the two clocks and can vary by a cycle in either domain.

Top module: `xdom_fifo`

## Requirements
- R1: While `rst_n` is low and right after it is released, `push_flag` is 0000, `push_afull` is 0, `pop_flag` is 0000, `pop_aempty` is 1, and both `*_flushing` outputs are 0.
- R2: Words leave in the order they were accepted. Whenever `pop_flag` is nonzero and `pop_flushing` is 0, `pop_data` shows the oldest stored word.
- R3: Once the pointers have settled and no flush is active, `push_flag` equals floor(n*15/DEPTH), where n is the number of stored words. It reads 1111 exactly when n equals DEPTH.
- R4: A push offered while the buffer is full is dropped. The level and the stored contents stay unchanged.
- R5: Once the pointers have settled and no flush is active, `pop_flag` equals floor(n*15/DEPTH). It reads 0000 exactly when the buffer is empty. A pop offered while the buffer is empty has no effect.
- R6: Outside a flush, `push_afull` is 1 when n >= DEPTH-1, and `pop_aempty` is 1 when n <= 1.
- R7: If `push_flush` is sampled high while `push_flushing` is 0, then `push_flushing` is 1 from the next push edge, with `push_flag` forced to 1111 and `push_afull` forced to 1. It falls within 20 push cycles. At that point `push_flag` is 0000 and `push_afull` is 0, and both sides then settle to empty.
- R8: If `pop_flush` is sampled high while `pop_flushing` is 0, then `pop_flushing` is 1 from the next pop edge, with `pop_flag` at 0000 and `pop_aempty` at 0. It falls within 20 pop cycles. At that point `pop_aempty` rises to 1 with `pop_flag` at 0000, and the push side then settles to empty.
- R9: While a side's `*_flushing` output is 1, that side's own push or pop requests are ignored, so the first word written after the flush is the first word read.
- R10: Flush requests raised at about the same time on both sides both complete, and both sides settle to empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| push_clk | input | 1 | Producer clock |
| pop_clk | input | 1 | Consumer clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| push_data | input | DW | Word to store |
| push_en | input | 1 | Store `push_data` on this push edge |
| push_flush | input | 1 | Request to discard all contents, producer side |
| push_flag | output | 4 | Quantized fill level seen by the producer |
| push_afull | output | 1 | At most one free slot (producer view) |
| push_flushing | output | 1 | Producer-side flush pending; push flags invalid |
| pop_en | input | 1 | Remove the oldest word on this pop edge |
| pop_flush | input | 1 | Request to discard all contents, consumer side |
| pop_data | output | DW | Oldest stored word |
| pop_flag | output | 4 | Quantized fill level seen by the consumer |
| pop_aempty | output | 1 | At most one stored word (consumer view) |
| pop_flushing | output | 1 | Consumer-side flush pending; pop flags invalid |

## Verification
The properties watch, on every edge of the matching clock, four things. Each published Gray pointer changes in one bit at a time or returns to zero. No word is taken while full and none is removed while empty. A flush request puts its side into the flushing state with the pointer at zero. A flushing side never advances its pointer. The bench scenarios cover what only shows up end to end: the quantized code at every fill level in both domains, the data order across wrap-around, completion of a flush started from either side or from both at once, and the fact that requests made during a flush leave no trace once it is over.

// File: rtl/xdom_pkg.sv
`timescale 1ns/1ps
package xdom_pkg;
    localparam int FLAG_W = 4;
    typedef logic [FLAG_W-1:0] flag_t;
    localparam flag_t FLAG_FULL  = 4'b1111;
    localparam flag_t FLAG_EMPTY = 4'b0000;
endpackage

// File: rtl/xdom_sync.sv
`timescale 1ns/1ps
// Two-stage synchronizer for a bundle of already glitch-free signals.
module xdom_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } st_t;

    st_t q, d;

    always_comb begin
        d    = q;
        d.s1 = din;
        d.s2 = q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign dout = q.s2;
endmodule

// File: rtl/xdom_store.sv
`timescale 1ns/1ps
// Storage array: written on the producer clock, read combinationally.
module xdom_store #(
    parameter int DW = 8,
    parameter int AW = 3
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/xdom_push_side.sv
`timescale 1ns/1ps
// Producer domain: write pointer, flush requester/responder, push flags.
module xdom_push_side
    import xdom_pkg::*;
#(
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_en,
    input  logic          push_flush,
    input  logic [AW:0]   rgray_s,
    input  logic          rreq_s,
    input  logic          rack_s,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wbin,
    output logic [AW:0]   wgray,
    output logic          wreq,
    output logic          wack,
    output logic          busy,
    output flag_t         flag,
    output logic          afull
);
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic          busy;
        logic          req;
        logic          ack;
        logic          rreq_seen;
        logic          rack_seen;
    } st_t;

    st_t q, d;

    function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    logic [PW-1:0] rbin_s, fill, fill_c;
    logic [PW+3:0] prod;
    logic          full_raw, req_evt, ack_evt, start;

    always_comb begin
        rbin_s   = g2b(rgray_s);
        fill     = q.bin - rbin_s;
        full_raw = fill >= PW'(DEPTH);
        fill_c   = full_raw ? PW'(DEPTH) : fill;
        req_evt  = rreq_s != q.rreq_seen;
        ack_evt  = rack_s != q.rack_seen;
        start    = !q.busy && push_flush;
        we       = !q.busy && !req_evt && !start && push_en && !full_raw;

        d           = q;
        d.rreq_seen = rreq_s;
        d.rack_seen = rack_s;
        if (req_evt || start) d.bin = '0;
        else if (we)          d.bin = q.bin + PW'(1);
        if (req_evt) d.ack = ~q.ack;
        if (start) begin
            d.req  = ~q.req;
            d.busy = 1'b1;
        end else if (q.busy && ack_evt) begin
            d.busy = 1'b0;
        end
        d.gray = d.bin ^ (d.bin >> 1);

        prod  = {4'b0000, fill_c} * (PW + 4)'(15);
        flag  = q.busy ? FLAG_FULL : flag_t'(prod >> AW);
        afull = q.busy || (fill_c >= PW'(DEPTH - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign waddr = q.bin[AW-1:0];
    assign wbin  = q.bin;
    assign wgray = q.gray;
    assign wreq  = q.req;
    assign wack  = q.ack;
    assign busy  = q.busy;
endmodule

// File: rtl/xdom_pop_side.sv
`timescale 1ns/1ps
// Consumer domain: read pointer, flush requester/responder, pop flags.
module xdom_pop_side
    import xdom_pkg::*;
#(
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop_en,
    input  logic          pop_flush,
    input  logic [AW:0]   wgray_s,
    input  logic          wreq_s,
    input  logic          wack_s,
    output logic          take,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rbin,
    output logic [AW:0]   rgray,
    output logic          rreq,
    output logic          rack,
    output logic          busy,
    output flag_t         flag,
    output logic          aempty
);
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic          busy;
        logic          req;
        logic          ack;
        logic          wreq_seen;
        logic          wack_seen;
    } st_t;

    st_t q, d;

    function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    logic [PW-1:0] wbin_s, fill, fill_c;
    logic [PW+3:0] prod;
    logic          empty_raw, req_evt, ack_evt, start;

    always_comb begin
        wbin_s    = g2b(wgray_s);
        fill      = wbin_s - q.bin;
        empty_raw = (fill == '0) || (fill > PW'(DEPTH));
        fill_c    = empty_raw ? '0 : fill;
        req_evt   = wreq_s != q.wreq_seen;
        ack_evt   = wack_s != q.wack_seen;
        start     = !q.busy && pop_flush;
        take      = !q.busy && !req_evt && !start && pop_en && !empty_raw;

        d           = q;
        d.wreq_seen = wreq_s;
        d.wack_seen = wack_s;
        if (req_evt || start) d.bin = '0;
        else if (take)        d.bin = q.bin + PW'(1);
        if (req_evt) d.ack = ~q.ack;
        if (start) begin
            d.req  = ~q.req;
            d.busy = 1'b1;
        end else if (q.busy && ack_evt) begin
            d.busy = 1'b0;
        end
        d.gray = d.bin ^ (d.bin >> 1);

        prod   = {4'b0000, fill_c} * (PW + 4)'(15);
        flag   = q.busy ? FLAG_EMPTY : flag_t'(prod >> AW);
        aempty = !q.busy && (fill_c <= PW'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign raddr = q.bin[AW-1:0];
    assign rbin  = q.bin;
    assign rgray = q.gray;
    assign rreq  = q.req;
    assign rack  = q.ack;
    assign busy  = q.busy;
endmodule

// File: rtl/xdom_fifo.sv
`timescale 1ns/1ps
module xdom_fifo
    import xdom_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 3
) (
    input  logic          push_clk,
    input  logic          pop_clk,
    input  logic          rst_n,
    input  logic [DW-1:0] push_data,
    input  logic          push_en,
    input  logic          push_flush,
    output logic [3:0]    push_flag,
    output logic          push_afull,
    output logic          push_flushing,
    input  logic          pop_en,
    input  logic          pop_flush,
    output logic [DW-1:0] pop_data,
    output logic [3:0]    pop_flag,
    output logic          pop_aempty,
    output logic          pop_flushing
);
    localparam int PW = AW + 1;
    localparam int XW = PW + 2;

    logic          w_we, r_take;
    logic [AW-1:0] w_addr, r_addr;
    logic [PW-1:0] w_bin, w_gray, r_bin, r_gray;
    logic          w_req, w_ack, r_req, r_ack;
    logic [XW-1:0] to_pop_s, to_push_s;
    flag_t         pf, rf;

    // pop-domain view of producer state
    xdom_sync #(.W(XW)) u_sync_w2r (
        .clk  (pop_clk),
        .rst_n(rst_n),
        .din  ({w_gray, w_req, w_ack}),
        .dout (to_pop_s)
    );

    // push-domain view of consumer state
    xdom_sync #(.W(XW)) u_sync_r2w (
        .clk  (push_clk),
        .rst_n(rst_n),
        .din  ({r_gray, r_req, r_ack}),
        .dout (to_push_s)
    );

    xdom_push_side #(.AW(AW)) u_push (
        .clk       (push_clk),
        .rst_n     (rst_n),
        .push_en   (push_en),
        .push_flush(push_flush),
        .rgray_s   (to_push_s[XW-1:2]),
        .rreq_s    (to_push_s[1]),
        .rack_s    (to_push_s[0]),
        .we        (w_we),
        .waddr     (w_addr),
        .wbin      (w_bin),
        .wgray     (w_gray),
        .wreq      (w_req),
        .wack      (w_ack),
        .busy      (push_flushing),
        .flag      (pf),
        .afull     (push_afull)
    );

    xdom_pop_side #(.AW(AW)) u_pop (
        .clk      (pop_clk),
        .rst_n    (rst_n),
        .pop_en   (pop_en),
        .pop_flush(pop_flush),
        .wgray_s  (to_pop_s[XW-1:2]),
        .wreq_s   (to_pop_s[1]),
        .wack_s   (to_pop_s[0]),
        .take     (r_take),
        .raddr    (r_addr),
        .rbin     (r_bin),
        .rgray    (r_gray),
        .rreq     (r_req),
        .rack     (r_ack),
        .busy     (pop_flushing),
        .flag     (rf),
        .aempty   (pop_aempty)
    );

    xdom_store #(.DW(DW), .AW(AW)) u_store (
        .wclk (push_clk),
        .we   (w_we),
        .waddr(w_addr),
        .wdata(push_data),
        .raddr(r_addr),
        .rdata(pop_data)
    );

    assign push_flag = pf;
    assign pop_flag  = rf;
endmodule

// File: rtl/xdom_fifo_chk.sv
`timescale 1ns/1ps
module xdom_fifo_chk #(
    parameter int AW = 3
) (
    input logic        push_clk,
    input logic        pop_clk,
    input logic        rst_n,
    input logic        push_flush,
    input logic        pop_flush,
    input logic        push_flushing,
    input logic        pop_flushing,
    input logic [3:0]  push_flag,
    input logic        push_afull,
    input logic [3:0]  pop_flag,
    input logic        pop_aempty,
    input logic        w_we,
    input logic        r_take,
    input logic [AW:0] w_bin,
    input logic [AW:0] w_gray,
    input logic [AW:0] r_bin,
    input logic [AW:0] r_gray
);
    AST_PUSH_FLUSH_ENTER: assert property (@(posedge push_clk) disable iff (!rst_n)
        push_flush && !push_flushing |=> push_flushing && (w_bin == '0)); // R7
    AST_POP_FLUSH_ENTER: assert property (@(posedge pop_clk) disable iff (!rst_n)
        pop_flush && !pop_flushing |=> pop_flushing && (r_bin == '0)); // R8
    AST_PUSH_FROZEN: assert property (@(posedge push_clk) disable iff (!rst_n)
        push_flushing |=> $stable(w_bin) || (w_bin == '0)); // R9
    AST_POP_FROZEN: assert property (@(posedge pop_clk) disable iff (!rst_n)
        pop_flushing |=> $stable(r_bin) || (r_bin == '0)); // R9
    AST_NO_OVERFLOW: assert property (@(posedge push_clk) disable iff (!rst_n)
        w_we |-> push_flag != 4'b1111); // R4
    AST_NO_UNDERFLOW: assert property (@(posedge pop_clk) disable iff (!rst_n)
        r_take |-> pop_flag != 4'b0000); // R5
    AST_FULL_AFULL: assert property (@(posedge push_clk) disable iff (!rst_n)
        push_flag == 4'b1111 |-> push_afull); // R6
    AST_EMPTY_AEMPTY: assert property (@(posedge pop_clk) disable iff (!rst_n)
        !pop_flushing && pop_flag == 4'b0000 |-> pop_aempty); // R6
    AST_WGRAY_STEP: assert property (@(posedge push_clk) disable iff (!rst_n)
        !$stable(w_gray) |-> (w_gray == '0) || ($countones(w_gray ^ $past(w_gray)) == 1)); // R2
    AST_RGRAY_STEP: assert property (@(posedge pop_clk) disable iff (!rst_n)
        !$stable(r_gray) |-> (r_gray == '0) || ($countones(r_gray ^ $past(r_gray)) == 1)); // R2
endmodule

bind xdom_fifo xdom_fifo_chk #(.AW(AW)) u_chk (
    .push_clk     (push_clk),
    .pop_clk      (pop_clk),
    .rst_n        (rst_n),
    .push_flush   (push_flush),
    .pop_flush    (pop_flush),
    .push_flushing(push_flushing),
    .pop_flushing (pop_flushing),
    .push_flag    (push_flag),
    .push_afull   (push_afull),
    .pop_flag     (pop_flag),
    .pop_aempty   (pop_aempty),
    .w_we         (w_we),
    .r_take       (r_take),
    .w_bin        (w_bin),
    .w_gray       (w_gray),
    .r_bin        (r_bin),
    .r_gray       (r_gray)
);

// File: tb/xdom_fifo_bench.sv
`timescale 1ns/1ps
module xdom_fifo_bench;
    localparam int DW    = 8;
    localparam int AW    = 3;
    localparam int DEPTH = 1 << AW;

    logic          push_clk = 1'b0, pop_clk = 1'b0, rst_n = 1'b0;
    logic [DW-1:0] push_data = '0;
    logic          push_en = 1'b0, push_flush = 1'b0;
    logic          pop_en = 1'b0, pop_flush = 1'b0;
    logic [3:0]    push_flag, pop_flag;
    logic          push_afull, push_flushing, pop_aempty, pop_flushing;
    logic [DW-1:0] pop_data;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] model[$];

    xdom_fifo #(.DW(DW), .AW(AW)) u_xdom_fifo (
        .push_clk(push_clk), .pop_clk(pop_clk), .rst_n(rst_n),
        .push_data(push_data), .push_en(push_en), .push_flush(push_flush),
        .push_flag(push_flag), .push_afull(push_afull), .push_flushing(push_flushing),
        .pop_en(pop_en), .pop_flush(pop_flush), .pop_data(pop_data),
        .pop_flag(pop_flag), .pop_aempty(pop_aempty), .pop_flushing(pop_flushing)
    );

    always #2.5 push_clk = ~push_clk;
    always #3.5 pop_clk  = ~pop_clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int qflag(input int n);
        return (n * 15) / DEPTH;
    endfunction

    task automatic settle();
        repeat (8) @(negedge pop_clk);
        repeat (8) @(negedge push_clk);
    endtask

    task automatic check_levels();
        int n = model.size();
        chk("R3 push_flag", push_flag, qflag(n));
        chk("R5 pop_flag", pop_flag, qflag(n));
        chk("R6 push_afull", push_afull, int'(n >= DEPTH - 1));
        chk("R6 pop_aempty", pop_aempty, int'(n <= 1));
    endtask

    task automatic push_word(input logic [DW-1:0] v);
        @(negedge push_clk);
        push_data = v;
        push_en   = 1'b1;
        @(negedge push_clk);
        push_en   = 1'b0;
        if (model.size() < DEPTH) model.push_back(v);
    endtask

    task automatic pop_word();
        @(negedge pop_clk);
        if (model.size() > 0) chk("R2 pop_data head", pop_data, model[0]);
        pop_en = 1'b1;
        @(negedge pop_clk);
        pop_en = 1'b0;
        if (model.size() > 0) void'(model.pop_front());
    endtask

    task automatic fill_to(input int k, input logic [DW-1:0] base);
        for (int i = 0; i < k; i++) push_word(base + DW'(i));
        settle();
    endtask

    task automatic probe_after_flush(input string req, input logic [DW-1:0] v);
        push_word(v);
        settle();
        chk({req, " fresh word count"}, pop_flag, qflag(1));
        pop_word();
        settle();
        check_levels();
    endtask

    task automatic push_flush_run(input int k);
        int n = 0;
        fill_to(k, DW'(8'h40 + k * 16));
        @(negedge push_clk);
        push_flush = 1'b1;
        push_en    = 1'b1;
        push_data  = 8'hEE;
        @(negedge push_clk);
        push_flush = 1'b0;
        chk("R7 flushing raised", push_flushing, 1);
        chk("R7 flag forced full", push_flag, 15);
        chk("R7 afull forced", push_afull, 1);
        while (push_flushing && n < 20) begin
            @(negedge push_clk);
            n++;
        end
        push_en = 1'b0;
        chk("R7 completes in time", int'(n < 20), 1);
        chk("R7 push_flag empty at done", push_flag, 0);
        chk("R7 afull low at done", push_afull, 0);
        model.delete();
        settle();
        check_levels();
        probe_after_flush("R9", DW'(8'h5A + k));
    endtask

    task automatic pop_flush_run(input int k);
        int n = 0;
        fill_to(k, DW'(8'h80 + k * 16));
        @(negedge pop_clk);
        pop_flush = 1'b1;
        pop_en    = 1'b1;
        @(negedge pop_clk);
        pop_flush = 1'b0;
        chk("R8 flushing raised", pop_flushing, 1);
        chk("R8 pop_flag 0000 while flushing", pop_flag, 0);
        chk("R8 aempty low while flushing", pop_aempty, 0);
        while (pop_flushing && n < 20) begin
            @(negedge pop_clk);
            n++;
        end
        pop_en = 1'b0;
        chk("R8 completes in time", int'(n < 20), 1);
        chk("R8 aempty marks completion", pop_aempty, 1);
        chk("R8 pop_flag empty at done", pop_flag, 0);
        model.delete();
        settle();
        check_levels();
        probe_after_flush("R9", DW'(8'hA5 + k));
    endtask

    initial begin
        #900000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge push_clk);
        chk("R1 push_flag in reset", push_flag, 0);
        chk("R1 pop_aempty in reset", pop_aempty, 1);
        rst_n = 1'b1;
        settle();
        chk("R1 push_flag", push_flag, 0);
        chk("R1 push_afull", push_afull, 0);
        chk("R1 pop_flag", pop_flag, 0);
        chk("R1 pop_aempty", pop_aempty, 1);
        chk("R1 push_flushing", push_flushing, 0);
        chk("R1 pop_flushing", pop_flushing, 0);

        // Sweep the fill level up and down, twice to cross pointer wrap.
        for (int pass = 0; pass < 2; pass++) begin
            check_levels();
            for (int k = 1; k <= DEPTH; k++) begin
                push_word(DW'(pass * 32 + k * 3));
                settle();
                check_levels();
            end
            push_word(8'hAB);           // R4: offered at full
            settle();
            chk("R4 level held at full", push_flag, 15);
            chk("R4 model size", model.size(), DEPTH);
            check_levels();
            for (int k = DEPTH; k >= 1; k--) begin
                pop_word();
                settle();
                check_levels();
            end
            pop_word();                 // R5: offered at empty
            settle();
            chk("R5 empty pop no effect", pop_flag, 0);
            push_word(8'h3C);
            settle();
            chk("R5 level one after refill", pop_flag, qflag(1));
            pop_word();
            settle();
            check_levels();
        end

        // Interleaved traffic: three pushes then one pop, repeatedly.
        for (int i = 0; i < 6; i++) begin
            if (model.size() < DEPTH - 2) begin
                push_word(DW'(8'hC0 + i));
                push_word(DW'(8'hD0 + i));
                push_word(DW'(8'hE0 + i));
            end
            settle();
            pop_word();
            settle();
            check_levels();
        end
        while (model.size() > 0) begin
            pop_word();
            settle();
        end
        check_levels();

        for (int k = 0; k <= DEPTH; k++) push_flush_run(k);
        for (int k = 0; k <= DEPTH; k++) pop_flush_run(k);

        // R10: both sides flush at about the same time.
        for (int k = 2; k <= 6; k += 4) begin
            int n = 0;
            fill_to(k, 8'h10);
            fork
                begin
                    @(negedge push_clk);
                    push_flush = 1'b1;
                    @(negedge push_clk);
                    push_flush = 1'b0;
                end
                begin
                    @(negedge pop_clk);
                    pop_flush = 1'b1;
                    @(negedge pop_clk);
                    pop_flush = 1'b0;
                end
            join
            while ((push_flushing || pop_flushing) && n < 40) begin
                @(negedge push_clk);
                n++;
            end
            chk("R10 both flushes complete", int'(n < 40), 1);
            model.delete();
            settle();
            chk("R10 push_flag empty", push_flag, 0);
            chk("R10 pop_flag empty", pop_flag, 0);
            check_levels();
            probe_after_flush("R10", 8'h77);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule